// File: doc/BRIEF.md
# Dual-Mode DDR Converter Readout Controller

This block sits on the host side of a fast 16-bit successive-approximation converter. It produces the conversion-start strobe at a programmable period, measured in system clock cycles. Once the worst-case conversion time has passed, it sends a burst of read clock pulses. It then assembles the returned bits, which arrive on both edges of the clock echoed back by the converter. Two wiring options are supported. In the one-lane option every bit arrives on lane A. In the two-lane option lane A carries the odd-numbered bits and lane B carries the even-numbered bits. Each finished word is delivered in the system clock domain as a one-cycle strobe with a 16-bit bus. The word can optionally be converted from two's complement to offset binary.

The echoed clock and the data lanes are registered twice in the system clock domain. A change on the echoed clock between those two stages marks a data edge. At that edge the older data stage, which holds the bit present before the edge, is shifted in. The read clock holds each phase for `RD_HALF` system cycles, so every echo edge is seen.

The sequencer has four states:
- `S_OFF` is the power-down state. It moves to `S_START` when `enable_i` is high.
- `S_START` drives the start strobe high for `CNV_HI` cycles, then moves to `S_CONV`.
- `S_CONV` lasts until `CONV_CYC` cycles after the start edge. On its last cycle it requests a burst, then moves to `S_GAP`.
- `S_GAP` holds the strobe low until the end of the period. It then returns to `S_START`, or to `S_OFF` if `enable_i` is low.

The burst engine has three states:
- `B_IDLE` accepts a request and moves to `B_HIGH`.
- `B_HIGH` and `B_LOW` alternate every `RD_HALF` cycles.
- After the last pulse, `B_LOW` returns to `B_IDLE`.

Top module: `adc_ddr_capture`

## Requirements
- R1: While reset is held, `cnv_o`, `rdclk_o`, `sample_valid_o` and `overrun_o` are all 0.
- R2: `cnv_o` is high for exactly `CNV_HI` (2) cycles in each period. The distance between rising edges equals `period_i`, but never less than a floor of max(`MIN_PERIOD`, `CNV_HI`+`CNV_LO`, `CONV_CYC`+1), which is 17 by default.
- R3: While `enable_i` is low, no new conversion starts. A period already in progress runs to its end.
- R4: The first rising edge of `rdclk_o` in a frame comes exactly `CONV_CYC` (16) cycles after the rising edge of `cnv_o`.
- R5: With `two_lane_i`=0 a burst has 8 pulses. The 16 bits arrive MSB first on `lane_a_i`, one bit per echo edge. The MSB is already present before the first edge.
- R6: With `two_lane_i`=1 a burst has 4 pulses. `lane_a_i` carries bits 15,13,…,1 and `lane_b_i` carries bits 14,12,…,0, one bit per echo edge on each lane, highest bit first.
- R7: After reset, and after each exit from `S_OFF`, the first two completed frames are not flagged on `sample_valid_o`. The third frame is flagged.
- R8: With `offset_bin_i`=1 bit 15 of the delivered word is inverted; with 0 the two's complement word is delivered unchanged.
- R9: `overrun_o` sets when a conversion start occurs while a burst is still running, and stays set until reset.
- R10: `two_lane_i` is sampled only when a conversion is launched. A change during a frame alters the burst of the next frame, not the current one.
- R11: `sample_valid_o` is high for a single cycle per delivered word, and `sample_o` holds that word while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; low parks the sequencer in power-down |
| period_i | input | PERIOD_W | Conversion period in system cycles |
| two_lane_i | input | 1 | 1 selects two-lane readout, 0 one-lane |
| offset_bin_i | input | 1 | 1 inverts the MSB of delivered words |
| cnv_o | output | 1 | Conversion-start strobe |
| rdclk_o | output | 1 | Read clock burst to the converter |
| dco_i | input | 1 | Echoed read clock from the converter |
| lane_a_i | input | 1 | Serial data lane A |
| lane_b_i | input | 1 | Serial data lane B |
| sample_valid_o | output | 1 | One-cycle strobe marking a new word |
| sample_o | output | 16 | Delivered sample |
| overrun_o | output | 1 | Sticky burst overrun flag |

## Verification
A wrong edge count or a wrong lane mode in the capture path shows up as a garbled word. It also shifts the delivered bits: one-lane data read in two-lane mode returns interleaved halves. All of this is visible within the same frame, about 35 cycles after the start edge. A skip counter that fails to reload on wake shows up as a strobe on the first or second frame, so the number of start edges seen before the first strobe is the observable. Errors in the sequencer counters appear directly in the strobe width, the period and the delay to the first read clock edge, one frame after they happen.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        S_OFF,
        S_START,
        S_CONV,
        S_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_HIGH,
        B_LOW
    } burst_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/conv_seq.sv
module conv_seq
    import adc_cap_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int CNV_HI     = 2,
    parameter int CNV_LO     = 2,
    parameter int CONV_CYC   = 16,
    parameter int MIN_PERIOD = 17
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                two_lane_i,
    output logic                cnv_o,
    output logic                start_o,
    output logic                burst_req_o,
    output logic                idle_o,
    output logic                mode_o
);

    localparam int FLOOR = max2(max2(MIN_PERIOD, CNV_HI + CNV_LO), CONV_CYC + 1);
    localparam logic [PERIOD_W-1:0] FLOOR_V  = PERIOD_W'(FLOOR);
    localparam logic [PERIOD_W-1:0] HI_LAST  = PERIOD_W'(CNV_HI - 1);
    localparam logic [PERIOD_W-1:0] CNV_LAST = PERIOD_W'(CONV_CYC - 1);

    seq_state_t          state_q, state_d;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] per_q;
    logic                mode_q;
    logic                period_end;
    logic                launch;
    logic [PERIOD_W-1:0] per_eff;

    assign period_end = (cnt_q == per_q - 1'b1);
    assign launch     = (state_d == S_START) && (state_q != S_START);
    assign per_eff    = (period_i < FLOOR_V) ? FLOOR_V : period_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:   if (enable_i) state_d = S_START;
            S_START: if (cnt_q == HI_LAST) state_d = S_CONV;
            S_CONV:  if (cnt_q == CNV_LAST) state_d = S_GAP;
            S_GAP:   if (period_end) state_d = enable_i ? S_START : S_OFF;
            default: state_d = S_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
            per_q   <= FLOOR_V;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch || state_q == S_OFF) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (launch) begin
                per_q  <= per_eff;
                mode_q <= two_lane_i;
            end
        end
    end

    always_comb begin
        cnv_o       = 1'b0;
        start_o     = 1'b0;
        burst_req_o = 1'b0;
        idle_o      = 1'b0;
        unique case (state_q)
            S_OFF:   idle_o = 1'b1;
            S_START: begin
                cnv_o   = 1'b1;
                start_o = (cnt_q == '0);
            end
            S_CONV:  burst_req_o = (cnt_q == CNV_LAST);
            S_GAP:   ;
            default: idle_o = 1'b1;
        endcase
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/rd_burst.sv
module rd_burst
    import adc_cap_pkg::*;
#(
    parameter int RD_HALF = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic two_lane_i,
    output logic rdclk_o,
    output logic busy_o,
    output logic accept_o
);

    localparam int PULSES_ONE = SAMPLE_W / 2;
    localparam int PULSES_TWO = SAMPLE_W / 4;
    localparam int PC_W       = $clog2(PULSES_ONE);
    localparam int PH_W       = (RD_HALF > 1) ? $clog2(RD_HALF) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RD_HALF - 1);

    burst_state_t    state_q, state_d;
    logic [PH_W-1:0] ph_q;
    logic [PC_W-1:0] pc_q;
    logic            mode_q;
    logic            half_end;
    logic [PC_W-1:0] pc_last;

    assign half_end = (ph_q == PH_LAST);
    assign pc_last  = mode_q ? PC_W'(PULSES_TWO - 1) : PC_W'(PULSES_ONE - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE: if (req_i) state_d = B_HIGH;
            B_HIGH: if (half_end) state_d = B_LOW;
            B_LOW:  if (half_end) state_d = (pc_q == pc_last) ? B_IDLE : B_HIGH;
            default: state_d = B_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= B_IDLE;
            ph_q    <= '0;
            pc_q    <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= (state_d != state_q) ? '0 : ph_q + 1'b1;
            if (state_q == B_IDLE && req_i) begin
                pc_q   <= '0;
                mode_q <= two_lane_i;
            end else if (state_q == B_LOW && half_end) begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end

    always_comb begin
        rdclk_o  = 1'b0;
        busy_o   = 1'b1;
        accept_o = 1'b0;
        unique case (state_q)
            B_IDLE: begin
                busy_o   = 1'b0;
                accept_o = req_i;
            end
            B_HIGH: rdclk_o = 1'b1;
            B_LOW:  ;
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ddr_deser.sv
module ddr_deser
    import adc_cap_pkg::*;
#(
    parameter int NLANES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                frame_start_i,
    input  logic                two_lane_i,
    input  logic                dco_i,
    input  logic [NLANES-1:0]   lane_i,
    output logic                done_o,
    output logic [SAMPLE_W-1:0] word_o
);

    localparam int EC_W = $clog2(SAMPLE_W + 1);
    localparam int HALF = SAMPLE_W / 2;

    logic                              dco_q1, dco_q2;
    logic [NLANES-1:0]                 ln_q1, ln_q2;
    logic                              active_q, mode_q;
    logic [EC_W-1:0]                   ecnt_q;
    logic                              edge_seen;
    logic                              shift_en;
    logic [EC_W-1:0]                   ecnt_last;
    logic [NLANES-1:0][SAMPLE_W-1:0]   lane_sr;
    logic [SAMPLE_W-1:0]               woven;

    assign edge_seen = dco_q1 ^ dco_q2;
    assign shift_en  = edge_seen && active_q;
    assign ecnt_last = mode_q ? EC_W'(HALF - 1) : EC_W'(SAMPLE_W - 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dco_q1 <= 1'b0;
            dco_q2 <= 1'b0;
            ln_q1  <= '0;
            ln_q2  <= '0;
        end else begin
            dco_q1 <= dco_i;
            dco_q2 <= dco_q1;
            ln_q1  <= lane_i;
            ln_q2  <= ln_q1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            active_q <= 1'b0;
            mode_q   <= 1'b0;
            ecnt_q   <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (frame_start_i) begin
                active_q <= 1'b1;
                mode_q   <= two_lane_i;
                ecnt_q   <= '0;
            end else if (shift_en) begin
                ecnt_q <= ecnt_q + 1'b1;
                if (ecnt_q == ecnt_last) begin
                    active_q <= 1'b0;
                    done_o   <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [SAMPLE_W-1:0] sr_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                sr_q <= '0;
            end else if (shift_en) begin
                sr_q <= {sr_q[SAMPLE_W-2:0], ln_q2[g]};
            end
        end
        assign lane_sr[g] = sr_q;
    end

    for (genvar i = 0; i < HALF; i++) begin : g_weave
        assign woven[2*i+1] = lane_sr[0][i];
        assign woven[2*i]   = lane_sr[1][i];
    end

    assign word_o = mode_q ? woven : lane_sr[0];

endmodule

// File: rtl/adc_ddr_capture.sv
module adc_ddr_capture
    import adc_cap_pkg::*;
#(
    parameter int PERIOD_W    = 16,
    parameter int CNV_HI      = 2,
    parameter int CNV_LO      = 2,
    parameter int CONV_CYC    = 16,
    parameter int MIN_PERIOD  = 17,
    parameter int RD_HALF     = 1,
    parameter int SKIP_FRAMES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                two_lane_i,
    input  logic                offset_bin_i,
    output logic                cnv_o,
    output logic                rdclk_o,
    input  logic                dco_i,
    input  logic                lane_a_i,
    input  logic                lane_b_i,
    output logic                sample_valid_o,
    output logic [15:0]         sample_o,
    output logic                overrun_o
);

    localparam int SK_W = $clog2(SKIP_FRAMES + 1);

    logic                start, burst_req, idle, mode;
    logic                busy, accept, done;
    logic [SAMPLE_W-1:0] word;
    logic [SK_W-1:0]     skip_q;

    conv_seq #(
        .PERIOD_W  (PERIOD_W),
        .CNV_HI    (CNV_HI),
        .CNV_LO    (CNV_LO),
        .CONV_CYC  (CONV_CYC),
        .MIN_PERIOD(MIN_PERIOD)
    ) seq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .period_i   (period_i),
        .two_lane_i (two_lane_i),
        .cnv_o      (cnv_o),
        .start_o    (start),
        .burst_req_o(burst_req),
        .idle_o     (idle),
        .mode_o     (mode)
    );

    rd_burst #(
        .RD_HALF(RD_HALF)
    ) burst_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (burst_req),
        .two_lane_i(mode),
        .rdclk_o   (rdclk_o),
        .busy_o    (busy),
        .accept_o  (accept)
    );

    ddr_deser #(
        .NLANES(2)
    ) deser_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .frame_start_i(accept),
        .two_lane_i   (mode),
        .dco_i        (dco_i),
        .lane_i       ({lane_b_i, lane_a_i}),
        .done_o       (done),
        .word_o       (word)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            skip_q         <= SK_W'(SKIP_FRAMES);
            sample_valid_o <= 1'b0;
            sample_o       <= '0;
            overrun_o      <= 1'b0;
        end else begin
            sample_valid_o <= done && (skip_q == '0);
            if (done) begin
                sample_o <= word ^ {offset_bin_i, {(SAMPLE_W-1){1'b0}}};
            end
            if (idle) begin
                skip_q <= SK_W'(SKIP_FRAMES);
            end else if (done && skip_q != '0) begin
                skip_q <= skip_q - 1'b1;
            end
            if (start && busy) begin
                overrun_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_ddr_capture_chk.sv
module adc_ddr_capture_chk #(
    parameter int CNV_HI = 2
) (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic cnv_o,
    input logic sample_valid_o,
    input logic overrun_o
);

    logic [7:0] hi_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hi_cnt <= '0;
        else         hi_cnt <= cnv_o ? hi_cnt + 1'b1 : 8'd0;
    end

    // R2
    cnv_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cnv_o) |-> (hi_cnt == 8'(CNV_HI)));

    // R3
    no_start_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable_i && !cnv_o) |=> !cnv_o);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o |=> overrun_o);

    // R9
    overrun_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(overrun_o) |-> ($past(cnv_o) && !$past(cnv_o, 2)));

    // R11
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_valid_o |=> !sample_valid_o);

endmodule

bind adc_ddr_capture adc_ddr_capture_chk #(
    .CNV_HI(CNV_HI)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .cnv_o         (cnv_o),
    .sample_valid_o(sample_valid_o),
    .overrun_o     (overrun_o)
);

// File: tb/adc_ddr_capture_tb_top.sv
module adc_ddr_capture_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PER        = 48;
    localparam int NVEC       = 8;
    // {word, two_lane, offset_bin}
    localparam logic [17:0] VEC [NVEC] = '{
        {16'h7FFF, 1'b0, 1'b0}, {16'h8000, 1'b1, 1'b0},
        {16'h0001, 1'b0, 1'b1}, {16'hFFFF, 1'b1, 1'b1},
        {16'hA5C3, 1'b0, 1'b0}, {16'h1234, 1'b1, 1'b0},
        {16'h5AF0, 1'b1, 1'b1}, {16'h8001, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] period = 16'(PER);
    logic        two_lane = 1'b0;
    logic        offs = 1'b0;
    logic        cnv, rdclk, valid, overrun;
    logic [15:0] sample;
    logic        dco = 1'b0, da = 1'b0, db = 1'b0;

    int  n_chk = 0, n_bad = 0;
    int  starts = 0, pulses = 0, last_pulses = 0;
    time t_rise = 0, t_prev = 0, t_fall = 0, t_rd = 0;
    bit  rd_wait = 0;

    logic [15:0] model_word = 16'h0;
    logic [15:0] m_sr = 16'h0, m_pend_word = 16'h0;
    logic        m_two = 1'b0, m_pend_two = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_ddr_capture dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .period_i(period),
        .two_lane_i(two_lane), .offset_bin_i(offs), .cnv_o(cnv), .rdclk_o(rdclk),
        .dco_i(dco), .lane_a_i(da), .lane_b_i(db),
        .sample_valid_o(valid), .sample_o(sample), .overrun_o(overrun)
    );

    // converter model: result loaded after the conversion, shifted on every read clock edge
    always begin
        @(posedge cnv);
        m_pend_two  = two_lane;
        m_pend_word = model_word;
        repeat (8) @(posedge clk);
        #1;
        m_two = m_pend_two;
        m_sr  = m_pend_word;
        da    = m_sr[15];
        db    = m_two ? m_sr[14] : 1'b0;
    end

    always @(rdclk) begin
        #1;
        dco  = rdclk;
        m_sr = m_two ? (m_sr << 2) : (m_sr << 1);
        da   = m_sr[15];
        db   = m_two ? m_sr[14] : 1'b0;
    end

    // monitors
    always @(posedge cnv) begin
        t_prev      = t_rise;
        t_rise      = $time;
        starts      = starts + 1;
        last_pulses = pulses;
        pulses      = 0;
        rd_wait     = 1;
    end
    always @(negedge cnv) t_fall = $time;
    always @(posedge rdclk) begin
        pulses = pulses + 1;
        if (rd_wait) begin
            t_rd    = $time;
            rd_wait = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_valid(output bit ok);
        ok = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (valid) begin
                ok = 1;
                return;
            end
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit ok;
        int s;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cnv", int'(cnv), 0);
        chk("R1 rdclk", int'(rdclk), 0);
        chk("R1 valid", int'(valid), 0);
        chk("R1 overrun", int'(overrun), 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R3 no start while disabled", starts, 0);

        for (int v = 0; v < NVEC; v++) begin
            model_word = VEC[v][17:2];
            two_lane   = VEC[v][1];
            offs       = VEC[v][0];
            starts     = 0;
            enable     = 1'b1;
            wait_valid(ok);
            chk("R7 valid presence", int'(ok), 1);
            chk("R7 starts before first valid", starts, 3);
            chk(two_lane ? (offs ? "R6 R8 two-lane word" : "R6 two-lane word")
                         : (offs ? "R5 R8 one-lane word" : "R5 one-lane word"),
                int'(sample), int'(offs ? (model_word ^ 16'h8000) : model_word));
            chk(two_lane ? "R6 pulse count" : "R5 pulse count", last_pulses, two_lane ? 4 : 8);
            if (v == 0) begin
                chk("R2 strobe width", int'((t_fall - t_rise) / CLK_PERIOD), 2);
                chk("R2 period", int'((t_rise - t_prev) / CLK_PERIOD), PER);
                chk("R4 read delay", int'((t_rd - t_rise) / CLK_PERIOD), 16);
            end
            @(negedge clk);
            chk("R11 single-cycle strobe", int'(valid), 0);
            enable = 1'b0;
            repeat (5) @(negedge clk);
            s = starts;
            repeat (60) @(negedge clk);
            chk("R3 no start after disable", starts, s);
        end

        // R10 mode change during a frame
        two_lane = 1'b0;
        offs     = 1'b0;
        enable   = 1'b1;
        @(posedge cnv);
        #1;
        repeat (3) @(negedge clk);
        two_lane = 1'b1;
        @(posedge cnv);
        #1;
        chk("R10 current frame keeps one-lane", last_pulses, 8);
        @(posedge cnv);
        #1;
        chk("R10 next frame uses two-lane", last_pulses, 4);
        @(negedge clk);
        enable = 1'b0;
        repeat (100) @(negedge clk);
        chk("R9 no overrun at legal period", int'(overrun), 0);

        // R2 floor and R9 overrun
        period = 16'd5;
        enable = 1'b1;
        repeat (3) @(posedge cnv);
        #1;
        chk("R2 period floor", int'((t_rise - t_prev) / CLK_PERIOD), 17);
        repeat (3) @(negedge clk);
        chk("R9 overrun set", int'(overrun), 1);
        period = 16'(PER);
        enable = 1'b0;
        repeat (100) @(negedge clk);
        chk("R9 overrun sticky", int'(overrun), 1);

        summary();
        $finish;
    end

endmodule